// File: doc/BRIEF.md
# Group-Scaled Int8 Matrix-Vector Engine

This block computes a dense matrix-vector product y = W·x, where both the weight matrix and the input vector hold signed 8-bit integers. Every row is split into equal groups of columns, and each group of weights and each group of inputs carries its own unsigned fixed-point scale. A start pulse makes the block copy the input vector into a local buffer in one pass, then copy the input group scales in a second pass. It then requests one burst of weight lines per row from an external memory, consumes 64 weights per beat over two 256-bit lanes, forms exact integer dot products per group, rescales each group sum by the product of its two scales, and accumulates the row result.

Rows and columns are parameters, so the same engine serves shapes such as 768x768, 768x2048, 2048x768 and 768x32000. Row results land in an internal result RAM at their row index and are read back through a synchronous read port once the single-cycle done pulse has been seen.

Top module: `gsmv_engine`

## Requirements
- R1: After synchronous reset, busy, done and wt_req are all 0.
- R2: Each operation issues exactly one weight burst request per row, in increasing row order, with line address row·(N_IN/64) and length N_IN/64, and never issues a new request while a burst is still open.
- R3: Group sums are exact signed integers for every int8 pair, including all -128·-128 and -128·127 groups, with no overflow.
- R4: Scales are unsigned Q8.16 in 24 bits; each group contributes floor(S·ws·xs / 2^16), so a negative sum with tiny scales rounds toward minus infinity.
- R5: The row result is the sum of its group contributions (signed, 16 fraction bits, ACC_W bits) written at the row index; the read port returns res_mem[res_raddr] one cycle after the address is presented.
- R6: Column c of a row sits in beat c/64 of that row's burst at element c mod 64; elements 0..31 are bytes of wt_lo and 32..63 of wt_hi, byte k at bits [8k+7:8k]. The input line on act_data uses the same element order over 512 bits.
- R7: A scale word packs the scales of the 64/GROUP groups covered by one line, group j of the line at bits [24j+23:24j]; the input scale word for line l comes from asc_addr = l, the weight scale word from wsc_addr = row·(N_IN/64) + beat, one cycle after the address.
- R8: Gaps of any length between weight beats do not change any result.
- R9: busy rises the cycle after an accepted start and falls in the same cycle that done is high; done is high for exactly one cycle per operation.
- R10: A start while busy is ignored: no extra burst requests, a single done pulse and unchanged results.
- R11: A new operation started right after done recomputes every row from freshly loaded inputs and scales.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| act_addr | output | LW | Input vector line address |
| act_data | input | 512 | Input vector line, one cycle after address |
| asc_addr | output | LW | Input scale word address |
| asc_data | input | GPB·24 | Input scale word, one cycle after address |
| wt_req | output | 1 | Burst request pulse |
| wt_req_line | output | WA_W | First weight line of the burst |
| wt_req_len | output | LEN_W | Burst length in lines |
| wt_valid | input | 1 | Weight beat present |
| wt_lo | input | 256 | Weight elements 0..31 of the beat |
| wt_hi | input | 256 | Weight elements 32..63 of the beat |
| wsc_addr | output | WA_W | Weight scale word address |
| wsc_data | input | GPB·24 | Weight scale word, one cycle after address |
| res_raddr | input | RW | Result RAM read address |
| res_rdata | output | ACC_W | Result RAM read data (one-cycle latency) |

## Verification
The bench goes after the extremes of the group sum, where a narrow accumulator would wrap and flip the sign of a full-scale -128·-128 group, and after tiny scales on negative sums, where a design that truncated toward zero or rescaled only once per row would return 0 instead of -1 or a differently rounded total. Beats arrive with varying gaps, which catches a design that counts cycles instead of valid beats or misaligns the scale word with its beat. A second start in the middle of a run would, if honoured, restart the loads and produce a surplus of burst requests or a second done pulse, and back-to-back runs expose a row accumulator that is not cleared between rows or operations.

// File: rtl/gsmv_pkg.sv
`timescale 1ns/1ps
package gsmv_pkg;
  localparam int LINE_ELEMS = 64;
  localparam int LANE_BITS  = 256;
  localparam int LINE_BITS  = 2 * LANE_BITS;
  localparam int SC_W       = 24;
  localparam int SC_FRAC    = 16;
  localparam int SP_W       = 2 * SC_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} eng_state_t;
  typedef enum logic [1:0] {LD_IDLE, LD_VEC, LD_SCL} load_state_t;
endpackage

// File: rtl/gsmv_inbuf.sv
`timescale 1ns/1ps
module gsmv_inbuf
  import gsmv_pkg::*;
#(
  parameter int N_IN  = 768,
  parameter int GROUP = 32,
  localparam int NLINES = N_IN / LINE_ELEMS,
  localparam int GPB    = LINE_ELEMS / GROUP,
  localparam int LW     = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int SW     = GPB * SC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  output logic [LW-1:0]        act_addr,
  input  logic [LINE_BITS-1:0] act_data,
  output logic [LW-1:0]        asc_addr,
  input  logic [SW-1:0]        asc_data,
  output logic                 ld_done,
  input  logic                 rd_en,
  input  logic [LW-1:0]        rd_line,
  output logic [LINE_BITS-1:0] x_line,
  output logic [SW-1:0]        xs_word
);

  load_state_t        ph;
  logic [LW-1:0]      cnt;
  logic               wr_vec, wr_scl;
  logic [LW-1:0]      wr_idx;

  logic [LINE_BITS-1:0] vec_ram [NLINES];
  logic [SW-1:0]        scl_ram [NLINES];

  assign act_addr = cnt;
  assign asc_addr = cnt;

  // Two sequential copy passes: vector lines first, then group scales.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= LD_IDLE;
      cnt     <= '0;
      wr_vec  <= 1'b0;
      wr_scl  <= 1'b0;
      wr_idx  <= '0;
      ld_done <= 1'b0;
    end else begin
      wr_vec  <= 1'b0;
      wr_scl  <= 1'b0;
      ld_done <= 1'b0;
      case (ph)
        LD_IDLE: begin
          if (go) begin
            ph  <= LD_VEC;
            cnt <= '0;
          end
        end
        LD_VEC: begin
          wr_vec <= 1'b1;
          wr_idx <= cnt;
          if (cnt == LW'(NLINES - 1)) begin
            ph  <= LD_SCL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LD_SCL: begin
          wr_scl <= 1'b1;
          wr_idx <= cnt;
          if (cnt == LW'(NLINES - 1)) begin
            ph      <= LD_IDLE;
            cnt     <= '0;
            ld_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= LD_IDLE;
      endcase
    end
  end

  // Block-RAM style buffers: synchronous write, registered read.
  always_ff @(posedge clk) begin
    if (wr_vec) vec_ram[wr_idx] <= act_data;
    if (wr_scl) scl_ram[wr_idx] <= asc_data;
    if (rd_en) begin
      x_line  <= vec_ram[rd_line];
      xs_word <= scl_ram[rd_line];
    end
  end

  // A load is only launched from idle; a busy engine must not restart it.
  assert_go_while_idle_R10: assert property (@(posedge clk) disable iff (rst)
    go |-> ph == LD_IDLE);

  // No buffer read may land while the copy passes are still running.
  assert_no_read_during_load_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (ph == LD_IDLE && !wr_vec));

endmodule

// File: rtl/gsmv_group_mac.sv
`timescale 1ns/1ps
module gsmv_group_mac
  import gsmv_pkg::*;
#(
  parameter int GROUP = 32,
  parameter int SUM_W = 22,
  localparam int GPB  = LINE_ELEMS / GROUP
) (
  input  logic                       clk,
  input  logic                       in_v,
  input  logic [LINE_BITS-1:0]       w_line,
  input  logic [LINE_BITS-1:0]       x_line,
  output logic [GPB-1:0][SUM_W-1:0]  sums
);

  logic signed [SUM_W-1:0] sum_c [GPB];

  // Exact integer dot product of each group within the 64-element line.
  always_comb begin
    for (int g = 0; g < GPB; g++) begin
      sum_c[g] = '0;
      for (int e = 0; e < GROUP; e++) begin
        sum_c[g] = sum_c[g] + SUM_W'(16'($signed(w_line[8*(g*GROUP+e) +: 8])) *
                                    16'($signed(x_line[8*(g*GROUP+e) +: 8])));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) begin
      for (int g = 0; g < GPB; g++) sums[g] <= sum_c[g];
    end
  end

endmodule

// File: rtl/gsmv_rescale.sv
`timescale 1ns/1ps
module gsmv_rescale
  import gsmv_pkg::*;
#(
  parameter int GPB   = 2,
  parameter int SUM_W = 22,
  parameter int ACC_W = 48,
  localparam int FW   = SUM_W + SP_W + 1
) (
  input  logic                       clk,
  input  logic                       sp_v,
  input  logic [GPB*SC_W-1:0]        ws_word,
  input  logic [GPB*SC_W-1:0]        xs_word,
  input  logic                       sum_v,
  input  logic [GPB-1:0][SUM_W-1:0]  sums,
  output logic [GPB-1:0][ACC_W-1:0]  contrib
);

  logic [SP_W-1:0]       sp   [GPB];
  logic signed [FW-1:0]  full [GPB];

  // Stage A: combined scale, computed alongside the group dot products.
  always_ff @(posedge clk) begin
    if (sp_v) begin
      for (int g = 0; g < GPB; g++)
        sp[g] <= SP_W'(ws_word[g*SC_W +: SC_W]) * SP_W'(xs_word[g*SC_W +: SC_W]);
    end
  end

  // Stage B: signed sum times unsigned Q16.32 scale, floored to 16 fraction bits.
  always_comb begin
    for (int g = 0; g < GPB; g++)
      full[g] = (FW'($signed(sums[g])) * FW'($signed({1'b0, sp[g]}))) >>> SC_FRAC;
  end

  always_ff @(posedge clk) begin
    if (sum_v) begin
      for (int g = 0; g < GPB; g++) contrib[g] <= full[g][ACC_W-1:0];
    end
  end

endmodule

// File: rtl/gsmv_engine.sv
`timescale 1ns/1ps
module gsmv_engine
  import gsmv_pkg::*;
#(
  parameter int N_IN  = 768,
  parameter int N_OUT = 768,
  parameter int GROUP = 32,
  parameter int ACC_W = 48,
  localparam int NLINES = N_IN / LINE_ELEMS,
  localparam int GPB    = LINE_ELEMS / GROUP,
  localparam int LW     = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int RW     = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int WA_W   = (N_OUT * NLINES > 1) ? $clog2(N_OUT * NLINES) : 1,
  localparam int LEN_W  = $clog2(NLINES + 1),
  localparam int SUM_W  = 16 + $clog2(GROUP) + 1,
  localparam int SW     = GPB * SC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic [LW-1:0]        act_addr,
  input  logic [LINE_BITS-1:0] act_data,
  output logic [LW-1:0]        asc_addr,
  input  logic [SW-1:0]        asc_data,
  output logic                 wt_req,
  output logic [WA_W-1:0]      wt_req_line,
  output logic [LEN_W-1:0]     wt_req_len,
  input  logic                 wt_valid,
  input  logic [LANE_BITS-1:0] wt_lo,
  input  logic [LANE_BITS-1:0] wt_hi,
  output logic [WA_W-1:0]      wsc_addr,
  input  logic [SW-1:0]        wsc_data,
  input  logic [RW-1:0]        res_raddr,
  output logic [ACC_W-1:0]     res_rdata
);

  initial assert_shape_ok_R6: assert ((N_IN % LINE_ELEMS == 0) && (LINE_ELEMS % GROUP == 0));

  eng_state_t       state;
  logic [RW-1:0]    row_idx;
  logic [LW-1:0]    beat_idx;
  logic             need_req;
  logic             burst_open;
  logic             accept, beat_last, ld_go, ld_done;

  assign accept     = wt_valid && (state == ST_RUN);
  assign beat_last  = (beat_idx == LW'(NLINES - 1));
  assign ld_go      = start && (state == ST_IDLE);
  assign wt_req_len = LEN_W'(NLINES);
  assign wsc_addr   = WA_W'(row_idx) * WA_W'(NLINES) + WA_W'(beat_idx);

  // Pipeline tags
  logic             v1, v2, v3;
  logic             last1, last2, last3;
  logic [RW-1:0]    row1, row2, row3;
  logic [LINE_BITS-1:0] w1;

  // Local input buffers
  logic [LINE_BITS-1:0] x_line;
  logic [SW-1:0]        xs_word;

  gsmv_inbuf #(.N_IN(N_IN), .GROUP(GROUP)) u_inbuf (
    .clk      (clk),
    .rst      (rst),
    .go       (ld_go),
    .act_addr (act_addr),
    .act_data (act_data),
    .asc_addr (asc_addr),
    .asc_data (asc_data),
    .ld_done  (ld_done),
    .rd_en    (accept),
    .rd_line  (beat_idx),
    .x_line   (x_line),
    .xs_word  (xs_word)
  );

  // Control: load passes, per-row burst requests, completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      row_idx     <= '0;
      beat_idx    <= '0;
      need_req    <= 1'b0;
      wt_req      <= 1'b0;
      wt_req_line <= '0;
    end else begin
      done   <= 1'b0;
      wt_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOAD;
            busy     <= 1'b1;
            row_idx  <= '0;
            beat_idx <= '0;
          end
        end
        ST_LOAD: begin
          if (ld_done) begin
            state    <= ST_RUN;
            need_req <= 1'b1;
          end
        end
        ST_RUN: begin
          if (need_req) begin
            wt_req      <= 1'b1;
            wt_req_line <= WA_W'(row_idx) * WA_W'(NLINES);
            need_req    <= 1'b0;
          end
          if (accept) begin
            if (beat_last) begin
              beat_idx <= '0;
              if (row_idx != RW'(N_OUT - 1)) begin
                row_idx  <= row_idx + 1'b1;
                need_req <= 1'b1;
              end
            end else begin
              beat_idx <= beat_idx + 1'b1;
            end
          end
          if (v3 && last3 && row3 == RW'(N_OUT - 1)) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) burst_open <= 1'b0;
    else if (wt_req) burst_open <= 1'b1;
    else if (accept && beat_last) burst_open <= 1'b0;
  end

  // Stage tags and captured beat
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      last1 <= 1'b0; last2 <= 1'b0; last3 <= 1'b0;
      row1 <= '0; row2 <= '0; row3 <= '0;
    end else begin
      v1 <= accept;   last1 <= accept && beat_last; row1 <= row_idx;
      v2 <= v1;       last2 <= last1;               row2 <= row1;
      v3 <= v2;       last3 <= last2;               row3 <= row2;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) w1 <= {wt_hi, wt_lo};
  end

  logic [GPB-1:0][SUM_W-1:0] sums;
  logic [GPB-1:0][ACC_W-1:0] contrib;

  gsmv_group_mac #(.GROUP(GROUP), .SUM_W(SUM_W)) u_mac (
    .clk    (clk),
    .in_v   (v1),
    .w_line (w1),
    .x_line (x_line),
    .sums   (sums)
  );

  gsmv_rescale #(.GPB(GPB), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_rescale (
    .clk     (clk),
    .sp_v    (v1),
    .ws_word (wsc_data),
    .xs_word (xs_word),
    .sum_v   (v2),
    .sums    (sums),
    .contrib (contrib)
  );

  // Row accumulation and result RAM
  logic signed [ACC_W-1:0] beat_sum;
  logic signed [ACC_W-1:0] acc;
  logic [ACC_W-1:0]        res_mem [N_OUT];

  always_comb begin
    beat_sum = '0;
    for (int g = 0; g < GPB; g++) beat_sum = beat_sum + $signed(contrib[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (v3) acc <= last3 ? '0 : acc + beat_sum;
  end

  always_ff @(posedge clk) begin
    if (v3 && last3) res_mem[row3] <= acc + beat_sum;
    res_rdata <= res_mem[res_raddr];
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_falls_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    wt_req |-> busy);

  assert_one_burst_open_R2: assert property (@(posedge clk) disable iff (rst)
    wt_req |-> !burst_open);

  assert_beat_inside_burst_R8: assert property (@(posedge clk) disable iff (rst)
    (wt_valid && state == ST_RUN) |-> burst_open);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (start && busy && state == ST_RUN) |=> state != ST_LOAD);

  assert_row_write_range_R5: assert property (@(posedge clk) disable iff (rst)
    (v3 && last3) |-> row3 < RW'(N_OUT));

endmodule

// File: tb/tb_gsmv_engine.sv
`timescale 1ns/1ps
module tb_gsmv_engine;
  localparam int NI = 128;
  localparam int NO = 6;
  localparam int GR = 32;
  localparam int AW = 48;
  localparam int NL = NI / 64;
  localparam int GP = 64 / GR;
  localparam int NG = NI / GR;
  localparam int LW = (NL > 1) ? $clog2(NL) : 1;
  localparam int RWB = (NO > 1) ? $clog2(NO) : 1;
  localparam int WA = (NO * NL > 1) ? $clog2(NO * NL) : 1;
  localparam int LN = $clog2(NL + 1);
  localparam int SWB = GP * 24;

  // Stimulus table: {pattern, scale mode, stall mode}
  localparam logic [11:0] VEC [8] = '{
    12'h000, 12'h010, 12'h100, 12'h211, 12'h020, 12'h312, 12'h011, 12'h222
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done;
  logic [LW-1:0] act_addr, asc_addr;
  logic [511:0] act_data;
  logic [SWB-1:0] asc_data, wsc_data;
  logic wt_req;
  logic [WA-1:0] wt_req_line, wsc_addr;
  logic [LN-1:0] wt_req_len;
  logic wt_valid = 1'b0;
  logic [255:0] wt_lo, wt_hi;
  logic [RWB-1:0] res_raddr = '0;
  logic [AW-1:0] res_rdata;

  always #2.5 clk = ~clk;

  gsmv_engine #(.N_IN(NI), .N_OUT(NO), .GROUP(GR), .ACC_W(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .act_addr(act_addr), .act_data(act_data), .asc_addr(asc_addr), .asc_data(asc_data),
    .wt_req(wt_req), .wt_req_line(wt_req_line), .wt_req_len(wt_req_len),
    .wt_valid(wt_valid), .wt_lo(wt_lo), .wt_hi(wt_hi),
    .wsc_addr(wsc_addr), .wsc_data(wsc_data),
    .res_raddr(res_raddr), .res_rdata(res_rdata)
  );

  logic signed [7:0] wm [NO*NI];
  logic signed [7:0] xv [NI];
  int unsigned wsc [NO*NG];
  int unsigned xsc [NG];
  longint expv [NO];

  int nchk = 0, nerr = 0;
  int req_cnt = 0, req_bad = 0;
  int stall_mode = 0;
  int cyc = 0;
  int b_line = 0, b_left = 0;
  int unsigned lcg = 1;

  function automatic logic [511:0] x_pack(int l);
    logic [511:0] r;
    for (int k = 0; k < 64; k++) r[8*k +: 8] = xv[l*64+k];
    return r;
  endfunction

  function automatic logic [511:0] w_pack(int l);
    logic [511:0] r;
    int row, bt;
    row = l / NL; bt = l % NL;
    for (int k = 0; k < 64; k++) r[8*k +: 8] = wm[row*NI + bt*64 + k];
    return r;
  endfunction

  function automatic logic [SWB-1:0] xs_pack(int l);
    logic [SWB-1:0] r;
    for (int j = 0; j < GP; j++) r[24*j +: 24] = xsc[l*GP+j][23:0];
    return r;
  endfunction

  function automatic logic [SWB-1:0] ws_pack(int a);
    logic [SWB-1:0] r;
    int row, bt;
    row = a / NL; bt = a % NL;
    for (int j = 0; j < GP; j++) r[24*j +: 24] = wsc[row*NG + bt*GP + j][23:0];
    return r;
  endfunction

  function automatic bit stall_ok(int c);
    case (stall_mode)
      1: return (c % 2) == 0;
      2: return (c % 5) == 0;
      default: return 1'b1;
    endcase
  endfunction

  // External memory model: one-cycle reads, one burst at a time.
  always @(posedge clk) begin
    cyc = cyc + 1;
    act_data <= x_pack(int'(act_addr));
    asc_data <= xs_pack(int'(asc_addr));
    wsc_data <= ws_pack(int'(wsc_addr));
    if (wt_req) begin
      if (int'(wt_req_line) != req_cnt * NL || int'(wt_req_len) != NL) req_bad = req_bad + 1;
      req_cnt = req_cnt + 1;
      b_line = int'(wt_req_line);
      b_left = int'(wt_req_len);
      wt_valid <= 1'b0;
    end else if (b_left > 0 && stall_ok(cyc)) begin
      wt_valid <= 1'b1;
      {wt_hi, wt_lo} <= w_pack(b_line);
      b_line = b_line + 1;
      b_left = b_left - 1;
    end else begin
      wt_valid <= 1'b0;
    end
  end

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic chk(string req, longint act, longint exp, string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(int pat, int sc, int seed);
    int unsigned v;
    lcg = 32'(seed) * 32'd7919 + 32'd17;
    for (int k = 0; k < NI; k++) begin
      v = rnd();
      case (pat)
        1: xv[k] = -8'sd128;
        2: xv[k] = 8'sd127;
        default: xv[k] = 8'(v >> 16);
      endcase
    end
    for (int i = 0; i < NO*NI; i++) begin
      v = rnd();
      case (pat)
        1, 2: wm[i] = -8'sd128;
        3: wm[i] = (i % 2 == 1) ? 8'sd127 : -8'sd127;
        default: wm[i] = 8'(v >> 16);
      endcase
    end
    for (int g = 0; g < NG; g++) begin
      v = rnd();
      xsc[g] = (sc == 0) ? 32'd65536 : (sc == 2) ? 32'd3 : ((v & 32'h3FFFF) | 32'd1);
    end
    for (int i = 0; i < NO*NG; i++) begin
      v = rnd();
      wsc[i] = (sc == 0) ? 32'd65536 : (sc == 2) ? 32'd1 : ((v & 32'h3FFFF) | 32'd1);
    end
    for (int r = 0; r < NO; r++) begin
      longint y, s, c;
      y = 0;
      for (int g = 0; g < NG; g++) begin
        s = 0;
        for (int e = 0; e < GR; e++)
          s += longint'(wm[r*NI + g*GR + e]) * longint'(xv[g*GR + e]);
        c = (s * (longint'(wsc[r*NG+g]) * longint'(xsc[g]))) >>> 16;
        y += c;
      end
      expv[r] = y;
    end
  endtask

  task automatic run_op(bit mid_start, string tag);
    int guard;
    bit seen;
    @(negedge clk);
    req_cnt = 0; req_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", longint'(busy), 1, "busy after start");
    guard = 0; seen = 1'b0;
    while (!seen && guard < 20000) begin
      @(negedge clk);
      guard++;
      start = (mid_start && (guard == 6 || guard == 20));
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    chk("R9", longint'(seen), 1, "done reached");
    chk("R9", longint'(busy), 0, "busy low with done");
    @(negedge clk);
    chk("R9", longint'(done), 0, "done lasts one cycle");
    chk("R2", longint'(req_cnt), NO, "burst request count");
    chk("R2", longint'(req_bad), 0, "burst request address/length errors");
    for (int r = 0; r < NO; r++) begin
      res_raddr = RWB'(r);
      @(negedge clk);
      chk({tag, "/R5"}, longint'($signed(res_rdata)), expv[r], $sformatf("row %0d", r));
    end
  endtask

  function automatic string tag_of(int pat, int sc, int st);
    if (sc == 2) return "R4";
    if (pat == 1 || pat == 2) return "R3";
    if (st != 0) return "R8";
    if (sc == 1) return "R7";
    return "R6";
  endfunction

  initial begin
    #(750_000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", longint'(busy), 0, "busy after reset");
    chk("R1", longint'(done), 0, "done after reset");
    chk("R1", longint'(wt_req), 0, "wt_req after reset");

    for (int i = 0; i < 8; i++) begin
      int pat, sc, st;
      pat = int'(VEC[i][11:8]);
      sc  = int'(VEC[i][7:4]);
      st  = int'(VEC[i][3:0]);
      stall_mode = st;
      fill(pat, sc, i + 3);
      run_op(1'b0, tag_of(pat, sc, st));
    end

    // R10: extra start pulses during a run are ignored
    stall_mode = 1;
    fill(0, 1, 41);
    run_op(1'b1, "R10");

    // R11: immediate new operation with fresh inputs and scales
    stall_mode = 0;
    fill(3, 0, 77);
    run_op(1'b0, "R11");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule